// File: doc/BRIEF.md
# Four-Layout CPU Program Bank Mapper

This block sits between a CPU address bus and the program memories of a cartridge-style system. It watches CPU writes to a small group of bank registers. For every CPU address from 0x6000 to 0xFFFF, it returns a physical bank number in 8 KB units and a flag that says whether that bank lives in RAM or in ROM. The region 0x8000–0xFFFF is split according to one of four layouts: a single 32 KB window; two 16 KB windows; one 16 KB window followed by two 8 KB windows; or four 8 KB windows. The region 0x6000–0x7FFF always maps to a RAM bank.

Most window registers carry a top bit that chooses RAM or ROM for their window. The register behind the highest window always maps ROM. A write strobe reaches RAM only after two protection registers hold their unlock values. The address decode from the bus to the outputs is purely combinational, and only the register state is clocked. The memories themselves sit outside the block.

Top module: `prog_bank_mapper`

## Requirements
- R1: After reset the layout is the four-window one (code 3). Every window register reads as ROM pointing at the last ROM bank (0x7F with defaults), and the 0x6000 RAM bank is 0.
- R2: A write to REG_BASE+0x00 sets the layout code from data bits 1:0. The codes are: 0 = one 32 KB window, 1 = two 16 KB windows, 2 = 16+8+8 KB, 3 = four 8 KB windows.
- R3: Addresses 0x6000–0x7FFF always select RAM, and the bank number is the low RAM_BANK_W bits of register REG_BASE+0x13, zero-extended.
- R4: In layout 3, the windows at 0x8000, 0xA000, 0xC000 and 0xE000 take bits 6:0 of REG_BASE+0x14, +0x15, +0x16 and +0x17 as the bank. For the first three, bit 7 = 0 selects RAM and bit 7 = 1 selects ROM.
- R5: In layout 2, 0x8000–0xBFFF is one 16 KB window from REG_BASE+0x15. Its bank is bits 6:1 of the register with address bit 13 as bit 0, and bit 7 selects RAM or ROM. 0xC000 maps 8 KB from REG_BASE+0x16, and 0xE000 maps 8 KB from REG_BASE+0x17.
- R6: In layout 1, 0x8000–0xBFFF is a 16 KB window from REG_BASE+0x15 (RAM or ROM by bit 7), and 0xC000–0xFFFF is a 16 KB ROM window from REG_BASE+0x17. In both, the bank is bits 6:1 of the register with address bit 13 as bit 0.
- R7: In layout 0, 0x8000–0xFFFF is one ROM window. Its bank is bits 6:2 of REG_BASE+0x17 with address bits 14:13 as the two low bits.
- R8: Register REG_BASE+0x17 always maps ROM, whatever its bit 7 holds.
- R9: mem_we is high only when cpu_wr is high, the address maps to RAM, REG_BASE+0x02 bits 1:0 equal 2, and REG_BASE+0x03 bits 1:0 equal 1.
- R10: A write strobe to an address currently mapped to ROM never raises mem_we.
- R11: Addresses below 0x6000 map nothing: bank_out is 0, bank_is_ram is 0 and mem_we is 0.
- R12: A register write takes effect on the clock edge that samples it. Registers latch their value in every layout, so a value written while a register is unused is used once the layout makes that register live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| bank_out | output | 7 | Physical bank number in 8 KB units |
| bank_is_ram | output | 1 | 1 when the address targets RAM, 0 for ROM or unmapped |
| mem_we | output | 1 | Write enable to the RAM |

## Verification
The assertions check, on every cycle, the properties that depend only on the region and on a tracked copy of the layout and unlock keys:
- the space below 0x6000 stays unmapped;
- 0x6000–0x7FFF is always RAM;
- the top window is always ROM;
- layout 0 is ROM, with the low bank bits following the address;
- mem_we never rises without a strobe, a RAM target and both keys.

The exact bank numbers for each layout and the per-window RAM/ROM bit can only be shown by the bench's scenarios. The same holds for the reset contents, and for registers written while unused that later become live. Those scenarios compare against a model of the register file.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    localparam int REG_W      = 8;
    localparam int N_WIN      = 4;
    localparam int KEY_W      = 2;
    localparam logic [KEY_W-1:0] KEY_A_OPEN = 2'd2;
    localparam logic [KEY_W-1:0] KEY_B_OPEN = 2'd1;

    localparam logic [7:0] OFS_LAYOUT = 8'h00;
    localparam logic [7:0] OFS_KEY_A  = 8'h02;
    localparam logic [7:0] OFS_KEY_B  = 8'h03;
    localparam logic [7:0] OFS_LOWRAM = 8'h13;
    localparam logic [7:0] OFS_WIN0   = 8'h14;

    typedef enum logic [1:0] {
        LAY_32K    = 2'd0,
        LAY_16_16  = 2'd1,
        LAY_16_8_8 = 2'd2,
        LAY_8X4    = 2'd3
    } layout_e;

    typedef struct packed {
        layout_e                          layout;
        logic [KEY_W-1:0]                 key_a;
        logic [KEY_W-1:0]                 key_b;
        logic [REG_W-1:0]                 lowram;
        logic [N_WIN-1:0][REG_W-1:0]      win;
    } cfg_t;

endpackage

// File: rtl/pbm_regs.sv
module pbm_regs
    import pbm_pkg::*;
#(
    parameter logic [15:0] REG_BASE      = 16'h5100,
    parameter int          LAST_ROM_BANK = 127
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic [7:0]  data,
    input  logic        wr,
    output cfg_t        cfg
);

    localparam logic [REG_W-2:0] LAST_B = LAST_ROM_BANK[REG_W-2:0];

    cfg_t cfg_d, cfg_q;
    logic page_hit;

    assign page_hit = wr && (addr[15:8] == REG_BASE[15:8]);

    always_comb begin
        cfg_d = cfg_q;
        if (page_hit) begin
            case (addr[7:0])
                OFS_LAYOUT: cfg_d.layout = layout_e'(data[1:0]);
                OFS_KEY_A:  cfg_d.key_a  = data[KEY_W-1:0];
                OFS_KEY_B:  cfg_d.key_b  = data[KEY_W-1:0];
                OFS_LOWRAM: cfg_d.lowram = data;
                default: ;
            endcase
            for (int i = 0; i < N_WIN; i++) begin
                if (addr[7:0] == OFS_WIN0 + 8'(i)) begin
                    cfg_d.win[i] = data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.layout <= LAY_8X4;
            cfg_q.key_a  <= '0;
            cfg_q.key_b  <= '0;
            cfg_q.lowram <= '0;
            for (int i = 0; i < N_WIN; i++) begin
                cfg_q.win[i] <= {1'b1, LAST_B};
            end
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/pbm_window_dec.sv
module pbm_window_dec
    import pbm_pkg::*;
#(
    parameter int RAM_BANK_W = 3
) (
    input  cfg_t              cfg,
    input  logic [15:0]       addr,
    output logic [REG_W-2:0]  bank,
    output logic              is_ram,
    output logic              mapped
);

    localparam int BANK_W = REG_W - 1;
    localparam int SEL_W  = $clog2(N_WIN);

    logic [1:0]        quarter;
    logic [SEL_W-1:0]  sel;
    logic [1:0]        span;
    logic [REG_W-1:0]  reg_v;
    logic [BANK_W-1:0] base;

    assign quarter = addr[14:13];

    always_comb begin
        sel  = '0;
        span = 2'd0;
        case (cfg.layout)
            LAY_32K: begin
                sel  = SEL_W'(N_WIN - 1);
                span = 2'd2;
            end
            LAY_16_16: begin
                sel  = quarter[1] ? SEL_W'(N_WIN - 1) : SEL_W'(1);
                span = 2'd1;
            end
            LAY_16_8_8: begin
                if (!quarter[1]) begin
                    sel  = SEL_W'(1);
                    span = 2'd1;
                end else begin
                    sel  = SEL_W'(quarter);
                    span = 2'd0;
                end
            end
            default: begin
                sel  = SEL_W'(quarter);
                span = 2'd0;
            end
        endcase
    end

    assign reg_v = cfg.win[sel];
    assign base  = reg_v[BANK_W-1:0];

    always_comb begin
        bank   = '0;
        is_ram = 1'b0;
        mapped = 1'b0;
        if (addr[15]) begin
            mapped = 1'b1;
            case (span)
                2'd2:    bank = {base[BANK_W-1:2], quarter};
                2'd1:    bank = {base[BANK_W-1:1], quarter[0]};
                default: bank = base;
            endcase
            is_ram = (sel != SEL_W'(N_WIN - 1)) && !reg_v[REG_W-1];
        end else if (addr[15:13] == 3'b011) begin
            mapped = 1'b1;
            is_ram = 1'b1;
            bank   = BANK_W'(cfg.lowram[RAM_BANK_W-1:0]);
        end
    end

endmodule

// File: rtl/pbm_write_gate.sv
module pbm_write_gate
    import pbm_pkg::*;
(
    input  logic [KEY_W-1:0] key_a,
    input  logic [KEY_W-1:0] key_b,
    input  logic             wr,
    input  logic             is_ram,
    input  logic             mapped,
    output logic             we
);

    logic unlocked;

    assign unlocked = (key_a == KEY_A_OPEN) && (key_b == KEY_B_OPEN);
    assign we       = wr && mapped && is_ram && unlocked;

endmodule

// File: rtl/prog_bank_mapper.sv
module prog_bank_mapper #(
    parameter logic [15:0] REG_BASE      = 16'h5100,
    parameter int          RAM_BANK_W    = 3,
    parameter int          LAST_ROM_BANK = 127
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [15:0]                 cpu_addr,
    input  logic [7:0]                  cpu_data,
    input  logic                        cpu_wr,
    output logic [pbm_pkg::REG_W-2:0]   bank_out,
    output logic                        bank_is_ram,
    output logic                        mem_we
);

    import pbm_pkg::*;

    cfg_t cfg;
    logic mapped;

    pbm_regs #(
        .REG_BASE      (REG_BASE),
        .LAST_ROM_BANK (LAST_ROM_BANK)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (cpu_addr),
        .data  (cpu_data),
        .wr    (cpu_wr),
        .cfg   (cfg)
    );

    pbm_window_dec #(
        .RAM_BANK_W (RAM_BANK_W)
    ) u_dec (
        .cfg    (cfg),
        .addr   (cpu_addr),
        .bank   (bank_out),
        .is_ram (bank_is_ram),
        .mapped (mapped)
    );

    pbm_write_gate u_gate (
        .key_a  (cfg.key_a),
        .key_b  (cfg.key_b),
        .wr     (cpu_wr),
        .is_ram (bank_is_ram),
        .mapped (mapped),
        .we     (mem_we)
    );

endmodule

// File: rtl/pbm_chk.sv
module pbm_chk #(
    parameter logic [15:0] REG_BASE = 16'h5100
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic        cpu_wr,
    input logic [6:0]  bank_out,
    input logic        bank_is_ram,
    input logic        mem_we
);

    logic [1:0] seen_layout;
    logic [1:0] seen_ka;
    logic [1:0] seen_kb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_layout <= 2'd3;
            seen_ka     <= 2'd0;
            seen_kb     <= 2'd0;
        end else if (cpu_wr) begin
            if (cpu_addr == REG_BASE)          seen_layout <= cpu_data[1:0];
            if (cpu_addr == REG_BASE + 16'h2)  seen_ka     <= cpu_data[1:0];
            if (cpu_addr == REG_BASE + 16'h3)  seen_kb     <= cpu_data[1:0];
        end
    end

    // R11
    low_space_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h6000) |-> (!bank_is_ram && bank_out == 7'd0 && !mem_we));

    // R3
    low_ram_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b011) |-> bank_is_ram);

    // R8
    top_window_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> !bank_is_ram);

    // R7
    single_window_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_layout == 2'd0 && cpu_addr[15]) |-> (!bank_is_ram && bank_out[1:0] == cpu_addr[14:13]));

    // R9
    we_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cpu_wr && bank_is_ram && seen_ka == 2'd2 && seen_kb == 2'd1));

endmodule

bind prog_bank_mapper pbm_chk #(.REG_BASE(REG_BASE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_data    (cpu_data),
    .cpu_wr      (cpu_wr),
    .bank_out    (bank_out),
    .bank_is_ram (bank_is_ram),
    .mem_we      (mem_we)
);

// File: tb/prog_bank_mapper_tb.sv
module prog_bank_mapper_tb;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] BASE       = 16'h5100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic [6:0]  bank_out;
    logic        bank_is_ram;
    logic        mem_we;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [1:0] m_layout;
    logic [1:0] m_ka, m_kb;
    logic [7:0] m_low;
    logic [7:0] m_win [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_bank_mapper u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr    (cpu_addr),
        .cpu_data    (cpu_data),
        .cpu_wr      (cpu_wr),
        .bank_out    (bank_out),
        .bank_is_ram (bank_is_ram),
        .mem_we      (mem_we)
    );

    function automatic logic [8:0] model(input logic [15:0] a, input logic w);
        logic [6:0] b;
        logic       r;
        logic [1:0] q;
        int         sel;
        b = '0; r = 1'b0; q = a[14:13]; sel = 0;
        if (a[15]) begin
            case (m_layout)
                2'd0: begin sel = 3; b = {m_win[3][6:2], q}; end
                2'd1: begin sel = q[1] ? 3 : 1; b = {m_win[sel][6:1], q[0]}; end
                2'd2: begin
                    if (!q[1]) begin sel = 1; b = {m_win[1][6:1], q[0]}; end
                    else begin sel = int'(q); b = m_win[sel][6:0]; end
                end
                default: begin sel = int'(q); b = m_win[sel][6:0]; end
            endcase
            r = (sel != 3) && !m_win[sel][7];
        end else if (a[15:13] == 3'b011) begin
            r = 1'b1;
            b = {4'b0, m_low[2:0]};
        end
        return {b, r, w && r && m_ka == 2'd2 && m_kb == 2'd1};
    endfunction

    function automatic string tag_for(input logic [15:0] a, input logic w);
        if (w) return "R9";
        if (a < 16'h6000) return "R11";
        if (a[15:13] == 3'b011) return "R3";
        case (m_layout)
            2'd0: return "R7";
            2'd1: return "R6";
            2'd2: return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic model_reset();
        m_layout = 2'd3; m_ka = 0; m_kb = 0; m_low = 0;
        for (int i = 0; i < 4; i++) m_win[i] = 8'hFF;
    endtask

    task automatic write_reg(input logic [7:0] ofs, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = BASE | 16'(ofs); cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        case (ofs)
            8'h00: m_layout = d[1:0];
            8'h02: m_ka = d[1:0];
            8'h03: m_kb = d[1:0];
            8'h13: m_low = d;
            8'h14: m_win[0] = d;
            8'h15: m_win[1] = d;
            8'h16: m_win[2] = d;
            8'h17: m_win[3] = d;
            default: ;
        endcase
    endtask

    task automatic probe(input logic [15:0] a, input logic w, input string tag);
        logic [8:0] exp;
        logic       ww;
        ww = w && (a[15:8] != BASE[15:8]);
        @(negedge clk);
        cpu_addr = a; cpu_wr = ww; cpu_data = 8'($urandom);
        #1;
        exp = model(a, ww);
        checks++;
        if ({bank_out, bank_is_ram, mem_we} !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual bank=%h ram=%b we=%b expected bank=%h ram=%b we=%b",
                     tag, a, bank_out, bank_is_ram, mem_we, exp[8:2], exp[1], exp[0]);
        end
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] ofs_list [8];
        void'($urandom(32'd4242));
        ofs_list = '{8'h00, 8'h02, 8'h03, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17};
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        probe(16'h8000, 1'b0, "R1");
        probe(16'hA123, 1'b0, "R1");
        probe(16'hC000, 1'b0, "R1");
        probe(16'hFFFF, 1'b0, "R1");
        probe(16'h6000, 1'b0, "R1");

        // R2: layout 0 spreads last bank group over four quarters
        write_reg(8'h00, 8'hFC);
        probe(16'h8000, 1'b0, "R2");
        probe(16'hA000, 1'b0, "R2");
        probe(16'hC000, 1'b0, "R2");
        probe(16'hE000, 1'b0, "R2");

        // R8: top register ignores its RAM bit
        write_reg(8'h00, 8'h03);
        write_reg(8'h17, 8'h05);
        probe(16'hE000, 1'b0, "R8");

        // R12: value stored while unused becomes live later
        write_reg(8'h00, 8'h02);
        write_reg(8'h14, 8'h0A);
        write_reg(8'h15, 8'h07);
        probe(16'h8000, 1'b0, "R12");
        probe(16'hA000, 1'b0, "R5");
        write_reg(8'h00, 8'h03);
        probe(16'h8000, 1'b0, "R12");

        // R6: 16 KB halves
        write_reg(8'h00, 8'h01);
        probe(16'h8000, 1'b0, "R6");
        probe(16'hBFFF, 1'b0, "R6");
        probe(16'hC000, 1'b0, "R6");

        // R9: unlock keys
        write_reg(8'h00, 8'h03);
        probe(16'h8000, 1'b1, "R9");
        write_reg(8'h02, 8'h02);
        write_reg(8'h03, 8'h01);
        probe(16'h8000, 1'b1, "R9");
        probe(16'h6010, 1'b1, "R9");
        write_reg(8'h03, 8'h03);
        probe(16'h6010, 1'b1, "R9");
        write_reg(8'h03, 8'h01);

        // R10: ROM window write strobe
        write_reg(8'h15, 8'h85);
        probe(16'hA000, 1'b1, "R10");
        probe(16'hE000, 1'b1, "R10");

        // R11: unmapped space
        probe(16'h4000, 1'b1, "R11");
        probe(16'h5FFF, 1'b0, "R11");

        // R3: low RAM bank uses low bits only
        write_reg(8'h13, 8'hFE);
        probe(16'h7FFF, 1'b0, "R3");

        for (int it = 0; it < 4000; it++) begin
            int r;
            r = int'($urandom % 4);
            if (r == 0) begin
                logic [7:0] o;
                logic [7:0] d;
                o = ofs_list[$urandom % 8];
                d = 8'($urandom);
                if (o == 8'h02 && ($urandom % 2 == 0)) d = 8'h02;
                if (o == 8'h03 && ($urandom % 2 == 0)) d = 8'h01;
                write_reg(o, d);
            end else begin
                logic [15:0] a;
                logic        w;
                a = 16'($urandom);
                if (r == 1) a[15] = 1'b1;
                w = 1'($urandom);
                probe(a, w, tag_for(a, w));
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule